// File: doc/BRIEF.md
# Lane-Partitioned 128-bit Vector Integer ALU

This block is a packed-integer execution unit for a vector pipeline. Each operation takes two 128-bit source vectors and a 128-bit accumulator vector. A lane-size code splits every operand into equal lanes of 8, 16, 32 or 64 bits, and the chosen operation is applied to all lanes at once. The operations are add, multiply, multiply-accumulate, and a broadcast that copies one scalar into every lane.

Each lane of the result depends only on the same lane of the inputs. Add and multiply-accumulate share one byte-segmented adder. A lane-boundary mask blocks the carry at each lane edge. The multiply has one bank of lane multipliers for each lane size, and the lane-size code picks which bank drives the result.

A request is a one-cycle `inValid` pulse. Two clock edges later the result appears, with a one-cycle `outValid` strobe. A new request can start in every cycle.

Top module: `simd_lane_alu`

## Requirements
- R1: While reset is held, and after it is released until the first result arrives, `outValid` is 0 and `result` is all zeros.
- R2: A request sampled with `inValid`=1 at a rising edge makes `outValid` high for exactly one cycle, after the second rising edge that follows. Requests in consecutive cycles give results in consecutive cycles, in the same order.
- R3: With `opSel`=0 (add), each lane of `result` is (srcA lane + srcB lane) mod 2^W. W is 8, 16, 32 or 64 for `laneSize` 0, 1, 2 or 3, and lane i occupies bits [i*W+W-1 : i*W]. A carry out of one lane never reaches the next lane.
- R4: With `opSel`=1 (multiply), each lane of `result` is the low W bits of srcA lane × srcB lane, with both operands unsigned. `accIn` has no effect.
- R5: With `opSel`=2 (multiply-accumulate), each lane of `result` is (accIn lane + srcA lane × srcB lane) mod 2^W.
- R6: With `opSel`=3 (broadcast), every lane of `result` equals srcA bits [W-1:0]. `srcB` and `accIn` have no effect.
- R7: In cycles with no new result, `result` keeps its last value, whatever the data and operation inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Request strobe; samples operands and codes |
| opSel | input | 2 | 0 add, 1 multiply, 2 multiply-accumulate, 3 broadcast |
| laneSize | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: 64-bit lanes |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| accIn | input | 128 | Accumulator vector for multiply-accumulate |
| outValid | output | 1 | One-cycle strobe marking a new result |
| result | output | 128 | Result vector |

## Verification
Some properties are checked on every cycle. The valid strobe must follow each request by two edges, and must never appear without one. The result must stay still when nothing commits. Three spot checks run against a plain reference: the 64-bit add lane, the low 32-bit multiply lane, and the 8-bit broadcast replication. The bench alone covers the full matrix of operations and lane sizes. That matrix includes the all-ones patterns that force a carry at every lane edge, the multiply-accumulate wraparound, the inputs that broadcast and multiply must ignore, and back-to-back request ordering.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_MUL   = 2'd1,
    OP_MAC   = 2'd2,
    OP_BCAST = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    LS_8  = 2'd0,
    LS_16 = 2'd1,
    LS_32 = 2'd2,
    LS_64 = 2'd3
  } laneSz_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    commit;
    logic    useMul;
    logic    useAcc;
    logic    useBcast;
    laneSz_e laneSz;
  } ctrlStrb_t;

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] addX,
  input  logic [VEC_W-1:0] addY,
  input  logic [1:0]       laneSz,
  output logic [VEC_W-1:0] sum
);
  localparam int NBYTES = VEC_W / 8;

  // byte ripple chain; the carry is cut wherever a lane starts
  always_comb begin
    logic        carry;
    logic [8:0]  part;
    logic [31:0] edgeMask;
    carry    = 1'b0;
    part     = '0;
    edgeMask = (32'd1 << laneSz) - 32'd1;
    sum      = '0;
    for (int j = 0; j < NBYTES; j++) begin
      if ((32'(j) & edgeMask) == 32'd0) carry = 1'b0;
      part = {1'b0, addX[j*8 +: 8]} + {1'b0, addY[j*8 +: 8]} + {8'd0, carry};
      sum[j*8 +: 8] = part[7:0];
      carry = part[8];
    end
  end
endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [1:0] opSel,
  input  logic [1:0] laneSize,
  output ctrlStrb_t strb,
  output logic      outValid
);
  logic    stage1Valid;
  opKind_e opQ;
  laneSz_e szQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
      opQ         <= OP_ADD;
      szQ         <= LS_8;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
      if (inValid) begin
        opQ <= opKind_e'(opSel);
        szQ <= laneSz_e'(laneSize);
      end
    end
  end

  always_comb begin
    strb.capture  = inValid;
    strb.commit   = stage1Valid;
    strb.useMul   = (opQ == OP_MUL) || (opQ == OP_MAC);
    strb.useAcc   = (opQ == OP_MAC);
    strb.useBcast = (opQ == OP_BCAST);
    strb.laneSz   = szQ;
  end

  // R2
  latency_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);
endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] accIn,
  output logic [VEC_W-1:0] resultQ
);
  localparam int NSIZES = 4;
  localparam int NBYTES = VEC_W / 8;

  logic [VEC_W-1:0] opA, opB, opC;
  logic [NSIZES-1:0][VEC_W-1:0] prodBySz, bcastBySz;
  logic [VEC_W-1:0] prodSel, addX, addY, sumOut, nextRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA <= '0;
      opB <= '0;
      opC <= '0;
    end else if (strb.capture) begin
      opA <= srcA;
      opB <= srcB;
      opC <= accIn;
    end
  end

  // one multiplier bank and one broadcast pattern per lane size
  for (genvar s = 0; s < NSIZES; s++) begin : gSz
    localparam int W = 8 << s;
    localparam int NL = VEC_W / W;
    for (genvar l = 0; l < NL; l++) begin : gLane
      assign prodBySz[s][l*W +: W] = opA[l*W +: W] * opB[l*W +: W];
    end
    assign bcastBySz[s] = {NL{opA[W-1:0]}};
  end

  assign prodSel = prodBySz[strb.laneSz];
  assign addX    = strb.useMul ? prodSel : opA;
  assign addY    = strb.useAcc ? opC : opB;

  simd_seg_adder #(.VEC_W(VEC_W)) uSegAdd (
    .addX  (addX),
    .addY  (addY),
    .laneSz(strb.laneSz),
    .sum   (sumOut)
  );

  always_comb begin
    if (strb.useBcast)                   nextRes = bcastBySz[strb.laneSz];
    else if (strb.useMul && !strb.useAcc) nextRes = prodSel;
    else                                 nextRes = sumOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            resultQ <= '0;
    else if (strb.commit) resultQ <= nextRes;
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(resultQ));

  // R3
  add_wide_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.useMul && !strb.useBcast && strb.laneSz == LS_64)
    |=> resultQ[63:0] == $past(opA[63:0]) + $past(opB[63:0]));

  // R4
  mul_low_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.useMul && !strb.useAcc && strb.laneSz == LS_32)
    |=> resultQ[31:0] == 32'($past(opA[31:0]) * $past(opB[31:0])));

  // R6
  bcast_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.useBcast && strb.laneSz == LS_8)
    |=> resultQ == {NBYTES{$past(opA[7:0])}});
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic [1:0]       laneSize,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] accIn,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  ctrlStrb_t strb;

  simd_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opSel   (opSel),
    .laneSize(laneSize),
    .strb    (strb),
    .outValid(outValid)
  );

  simd_datapath #(.VEC_W(VEC_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .srcA   (srcA),
    .srcB   (srcB),
    .accIn  (accIn),
    .resultQ(result)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && result == '0));
endmodule

// File: tb/simd_lane_alu_test.sv
`timescale 1ns/1ps
module simd_lane_alu_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   opSel = 2'd0;
  logic [1:0]   laneSize = 2'd0;
  logic [127:0] srcA = '0, srcB = '0, accIn = '0;
  logic         outValid;
  logic [127:0] result;
  int total = 0;
  int bad = 0;

  simd_lane_alu uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .laneSize(laneSize), .srcA(srcA), .srcB(srcB), .accIn(accIn),
    .outValid(outValid), .result(result)
  );

  always #2 clk = ~clk;

  function automatic logic [127:0] model(int op, int sz, logic [127:0] a,
                                         logic [127:0] b, logic [127:0] c);
    int w, n;
    logic [63:0] m, x, y, z, e;
    logic [127:0] r;
    w = 8 << sz;
    n = 128 / w;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    r = '0;
    for (int i = 0; i < n; i++) begin
      x = 64'(a >> (i*w)) & m;
      y = 64'(b >> (i*w)) & m;
      z = 64'(c >> (i*w)) & m;
      case (op)
        0: e = x + y;
        1: e = x * y;
        2: e = z + x * y;
        default: e = a[63:0];
      endcase
      e = e & m;
      r = r | ({64'd0, e} << (i*w));
    end
    return r;
  endfunction

  function automatic string reqOf(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(int op, int sz, logic [127:0] a, logic [127:0] b, logic [127:0] c);
    opSel = 2'(op); laneSize = 2'(sz);
    srcA = a; srcB = b; accIn = c;
    inValid = 1'b1;
  endtask

  // one request, serialized: check valid timing and the result
  task automatic runOne(int op, int sz, logic [127:0] a, logic [127:0] b, logic [127:0] c);
    logic [127:0] exp;
    exp = model(op, sz, a, b, c);
    @(negedge clk);
    drive(op, sz, a, b, c);
    @(negedge clk);
    inValid = 1'b0;
    chk("R2", {127'd0, outValid}, 128'd0);
    @(negedge clk);
    chk("R2", {127'd0, outValid}, 128'd1);
    chk(reqOf(op), result, exp);
  endtask

  initial begin
    logic [127:0] a, b, c, held;
    logic [127:0] e0, e1, e2;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk("R1", {127'd0, outValid}, 128'd0);
    chk("R1", result, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", {127'd0, outValid}, 128'd0);
    chk("R1", result, 128'd0);

    // full matrix of operations x lane sizes x patterns (R3..R6)
    for (int op = 0; op < 4; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int k = 0; k < 8; k++) begin
          case (k)
            0: begin a = '1; b = '1; c = '1; end               // carry at every lane edge
            1: begin a = {16{8'h80}}; b = {16{8'h80}}; c = {16{8'hFF}}; end
            2: begin a = 128'h0123456789ABCDEF_FEDCBA9876543210;
                     b = 128'hF0E1D2C3B4A59687_78695A4B3C2D1E0F;
                     c = 128'h5555AAAA5555AAAA_AAAA5555AAAA5555; end
            3: begin a = '1; b = 128'd1; c = '0; end
            default: begin
              a = {$urandom, $urandom, $urandom, $urandom};
              b = {$urandom, $urandom, $urandom, $urandom};
              c = {$urandom, $urandom, $urandom, $urandom};
            end
          endcase
          runOne(op, sz, a, b, c);
        end
      end
    end

    // exhaustive 8-bit operand sweep: all 256 values of srcA lanes (R3, R4)
    for (int k = 0; k < 16; k++) begin
      a = '0; b = '0;
      for (int l = 0; l < 16; l++) begin
        a[l*8 +: 8] = 8'(k*16 + l);
        b[l*8 +: 8] = 8'(255 - k*16 - l*3);
      end
      runOne(0, 0, a, b, '1);
      runOne(1, 0, a, b, '1);
    end

    // R6: same broadcast source, different srcB/accIn -> same result
    runOne(3, 1, 128'h1234, '0, '0);
    runOne(3, 1, 128'h1234, '1, {4{32'hDEADBEEF}});
    // R4: accIn ignored by multiply
    runOne(1, 2, {4{32'h00010003}}, {4{32'h00020005}}, '1);

    // R2: back-to-back requests
    @(negedge clk);
    e0 = model(0, 0, '1, 128'd1, '0);
    e1 = model(1, 3, {2{64'hFFFF_FFFF_0000_0002}}, {2{64'h3}}, '0);
    e2 = model(2, 1, {8{16'h0102}}, {8{16'h0304}}, {8{16'hFFF0}});
    drive(0, 0, '1, 128'd1, '0);
    @(negedge clk);
    drive(1, 3, {2{64'hFFFF_FFFF_0000_0002}}, {2{64'h3}}, '0);
    @(negedge clk);
    drive(2, 1, {8{16'h0102}}, {8{16'h0304}}, {8{16'hFFF0}});
    chk("R2", {127'd0, outValid}, 128'd1);
    chk("R2", result, e0);
    @(negedge clk);
    inValid = 1'b0;
    chk("R2", {127'd0, outValid}, 128'd1);
    chk("R2", result, e1);
    @(negedge clk);
    chk("R2", {127'd0, outValid}, 128'd1);
    chk("R2", result, e2);
    @(negedge clk);
    chk("R2", {127'd0, outValid}, 128'd0);

    // R7: inputs change without a request; result is held
    held = result;
    opSel = 2'd3; laneSize = 2'd2;
    srcA = '1; srcB = '1; accIn = '1;
    repeat (4) @(negedge clk);
    chk("R7", result, held);
    chk("R7", {127'd0, outValid}, 128'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule